// File: doc/BRIEF.md
# Cascadable 32-Line Interrupt Aggregator

This block collects 32 interrupt request lines into a single wired interrupt output. Each line is synchronized, then captured into a pending (cause) register. Each pending bit is gated by a per-line mask bit. One global control bit chooses how every line is captured: rising-edge latching or level sensing. The combined output can drive a parent CPU interrupt controller, or it can feed one input of another instance of this block, which builds a tree.

Software uses a small 32-bit register port with an address, a write strobe with data, and a read strobe whose data appears on the next cycle. Reading the cause register returns the raw pending bits, before masking. The interrupt handler applies its own copy of the mask to find the lines it must service. To acknowledge pending bits, software writes zeros at their positions. Bits written as one are left unchanged.

Top module: `irqagg_top`

## Requirements
- R1: After reset the cause register reads 0x0000_0000, the mask register reads 0xFFFF_FFFF, the control register reads 0x0000_0000, and irq_out is low.
- R2: The cause register sits at offset 0x00, the mask register at 0x10 and the control register at 0x28. A read strobe sampled at a rising clock edge puts the selected register on reg_rdata after that edge. reg_rdata then holds that value until the next read strobe.
- R3: Mask bit i set to 1 blocks line i, and mask bit i set to 0 passes it. irq_out is high exactly when some cause bit is 1 and its mask bit is 0. Reads of the cause register return the bits before masking.
- R4: A write to the cause register clears every bit whose data bit is 0 and leaves every bit whose data bit is 1 unchanged. Writing all zeros therefore clears all pending bits.
- R5: With control bit 3 set to 1 (edge mode), a 0-to-1 change on a line sets its cause bit. The bit stays set until it is acknowledged. A change driven just after a clock edge reaches the cause register, and irq_out, at the third rising edge after it, because of the two-flop synchronizer.
- R6: With control bit 3 set to 0 (level mode), a cause bit is set on every cycle its synchronized line is high. An acknowledge while the line is still high therefore leaves the bit set.
- R7: In edge mode, if a new rising edge and an acknowledge of the same bit land in the same cycle, the new edge wins and the bit stays set.
- R8: Control bit 5 (message-delivery mask) is stored and read back but affects nothing else. All control bits other than 3 and 5 read as 0.
- R9: Reads of any offset other than 0x00, 0x10 and 0x28 return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Asynchronous interrupt request lines |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The bench lines up an edge-mode acknowledge with a fresh rising edge on the same line. A design that gave the clear priority would silently lose that interrupt. It also acknowledges a level-mode line while the line is still held high. A design that let the clear win would report the line idle while the source still asserts it. Partial acknowledges with mixed data bits expose a design that reads the write as write-one-to-clear. Counting exact cycles to irq_out exposes a synchronizer that is one stage short or one stage long. Writes to unmapped offsets, and all-ones writes to control, expose loose address decoding and reserved bits that are stored when they should not be.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h28;

  localparam int unsigned CTRL_EDGE_BIT = 3;
  localparam int unsigned CTRL_MSG_BIT  = 5;
  localparam logic [DATA_W-1:0] CTRL_KEEP =
    (DATA_W'(1) << CTRL_EDGE_BIT) | (DATA_W'(1) << CTRL_MSG_BIT);

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_MASK,
    SEL_CTRL
  } regsel_e;

  function automatic regsel_e decode_off(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_CAUSE: return SEL_CAUSE;
      OFF_MASK:  return SEL_MASK;
      OFF_CTRL:  return SEL_CTRL;
      default:   return SEL_NONE;
    endcase
  endfunction

  // new set wins over a clear in the same cycle
  function automatic logic [DATA_W-1:0] next_cause(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] set,
                                                   input logic [DATA_W-1:0] clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic any_unmasked(input logic [DATA_W-1:0] cause,
                                        input logic [DATA_W-1:0] mask);
    return |(cause & ~mask);
  endfunction
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[k] <= '0;
          else        stg_q[k] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[k] <= '0;
          else        stg_q[k] <= stg_q[k-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sync_in,
  input  logic              edge_mode,
  input  logic              ack_we,
  input  logic [DATA_W-1:0] ack_data,
  output logic [DATA_W-1:0] cause_q
);
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] rise_vec;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;

  generate
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_line
      assign rise_vec[gi] = sync_in[gi] & ~prev_q[gi];
      assign set_vec[gi]  = edge_mode ? rise_vec[gi] : sync_in[gi];
      assign clr_vec[gi]  = ack_we & ~ack_data[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= sync_in;
      cause_q <= next_cause(cause_q, set_vec, clr_vec);
    end
  end

  // R4: zero-written bits are cleared unless a set arrives
  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((cause_q & ~$past(ack_data) & ~$past(set_vec)) == '0));

  // R5: in edge mode with no acknowledge, pending bits persist
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !ack_we) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R6: level mode sets each high line
  p_level_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> ((cause_q & $past(sync_in)) == $past(sync_in)));

  // R7: a rise coinciding with an acknowledge keeps the bit
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack_we) |=> ((cause_q & $past(rise_vec)) == $past(rise_vec)));
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_re,
  input  logic [DATA_W-1:0] cause_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ack_we,
  output logic              edge_mode
);
  regsel_e           sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel       = decode_off(reg_addr);
  assign ack_we    = reg_we && (sel == SEL_CAUSE);
  assign edge_mode = ctrl_q[CTRL_EDGE_BIT];

  always_comb begin
    case (sel)
      SEL_CAUSE: rd_mux = cause_q;
      SEL_MASK:  rd_mux = mask_q;
      SEL_CTRL:  rd_mux = ctrl_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      ctrl_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && sel == SEL_MASK) mask_q <= reg_wdata;
      if (reg_we && sel == SEL_CTRL) ctrl_q <= reg_wdata & CTRL_KEEP;
      if (reg_re)                    reg_rdata <= rd_mux;
    end
  end

  // R9: unmapped writes leave mask and control untouched
  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_NONE) |=> ($stable(mask_q) && $stable(ctrl_q)));

  // R2: read data only moves after a read strobe
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] irq_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_re,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic [DATA_W-1:0] sync_lines;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              ack_we;
  logic              edge_mode;

  irqagg_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_in),
    .dout (sync_lines)
  );

  irqagg_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_lines),
    .edge_mode(edge_mode),
    .ack_we   (ack_we),
    .ack_data (reg_wdata),
    .cause_q  (cause_q)
  );

  irqagg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_re   (reg_re),
    .cause_q  (cause_q),
    .mask_q   (mask_q),
    .ctrl_q   (ctrl_q),
    .reg_rdata(reg_rdata),
    .ack_we   (ack_we),
    .edge_mode(edge_mode)
  );

  assign irq_out = any_unmasked(cause_q, mask_q);

  // R3: with every line masked the output stays low
  p_all_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_out);

  // R1: coming out of reset nothing is pending
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (cause_q == '0 && !irq_out));
endmodule

// File: tb/sim_irqagg_top.sv
module sim_irqagg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irqagg_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  localparam logic [7:0] A_CAUSE = 8'h00;
  localparam logic [7:0] A_MASK  = 8'h10;
  localparam logic [7:0] A_CTRL  = 8'h28;
  localparam logic [31:0] EDGE_ON = 32'h0000_0008;

  // {edge_mode, ack_while_high, mask[31:0], pattern[31:0]}
  localparam int NV = 8;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0001},
    {1'b0, 1'b1, 32'h0000_0000, 32'h8000_0000},
    {1'b1, 1'b0, 32'h0000_0000, 32'hA5A5_0F0F},
    {1'b1, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0100},
    {1'b0, 1'b0, 32'hFFFF_FFFE, 32'h0000_0003},
    {1'b0, 1'b0, 32'h0000_0003, 32'h0000_0003},
    {1'b1, 1'b0, 32'h7FFF_FFFF, 32'h8000_0001}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
    rd(A_CAUSE, d); chk("R1 cause", d, 32'h0);
    rd(A_MASK, d);  chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
    // R2 read data holds without a strobe
    idle(3); chk("R2 rdata hold", reg_rdata, 32'h0);

    // table walk: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic        em, ackh;
      logic [31:0] msk, pat;
      {em, ackh, msk, pat} = VEC[v];
      irq_in = '0; idle(4);
      wr(A_CTRL, em ? EDGE_ON : 32'h0);
      wr(A_MASK, msk);
      wr(A_CAUSE, 32'h0);
      @(negedge clk); irq_in = pat;
      idle(4);
      if (ackh) wr(A_CAUSE, 32'h0);
      exp_c = (em && ackh) ? 32'h0 : pat;
      rd(A_CAUSE, d);
      chk(em ? (ackh ? "R4/R5 table cause" : "R5 table cause")
             : (ackh ? "R6 table cause" : "R6 table cause"), d, exp_c);
      chk("R3 table irq_out", {31'd0, irq_out}, {31'd0, |(exp_c & ~msk)});
      irq_in = '0;
    end

    // R5 latency: three edges from input change to irq_out
    wr(A_CTRL, EDGE_ON); wr(A_MASK, 32'h0); wr(A_CAUSE, 32'h0);
    idle(4);
    @(negedge clk); irq_in = 32'h0000_0040;
    @(negedge clk); chk("R5 after 1 edge", {31'd0, irq_out}, 32'd0);
    @(negedge clk); chk("R5 after 2 edges", {31'd0, irq_out}, 32'd0);
    @(negedge clk); chk("R5 after 3 edges", {31'd0, irq_out}, 32'd1);
    irq_in = '0; idle(4);
    rd(A_CAUSE, d); chk("R5 held after release", d, 32'h0000_0040);

    // R4 partial acknowledge
    wr(A_CAUSE, 32'h0);
    @(negedge clk); irq_in = 32'h0000_00F0;
    idle(4); irq_in = '0; idle(4);
    wr(A_CAUSE, 32'hFFFF_FF5F);
    rd(A_CAUSE, d); chk("R4 partial ack", d, 32'h0000_0050);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, d); chk("R4 clear all", d, 32'h0);

    // R7 new edge coincides with acknowledge
    @(negedge clk); irq_in = 32'h0000_0210;
    idle(4); irq_in = '0; idle(4);
    rd(A_CAUSE, d); chk("R7 setup", d, 32'h0000_0210);
    @(negedge clk); irq_in = 32'h0000_0010;
    @(negedge clk);
    @(negedge clk);
    reg_addr = A_CAUSE; reg_wdata = 32'h0; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    rd(A_CAUSE, d); chk("R7 edge wins", d, 32'h0000_0010);
    irq_in = '0; idle(4);
    wr(A_CAUSE, 32'h0);

    // R8 control bits
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R8 ctrl readback", d, 32'h0000_0028);
    chk("R8 bit5 no effect idle", {31'd0, irq_out}, 32'd0);
    @(negedge clk); irq_in = 32'h0000_0001;
    idle(4);
    chk("R8 bit5 no effect irq", {31'd0, irq_out}, 32'd1);
    irq_in = '0; idle(4);

    // R9 unmapped offsets
    wr(8'h04, 32'h0);
    wr(8'h14, 32'h1234_5678);
    wr(8'h2C, 32'h0);
    rd(A_CAUSE, d); chk("R9 cause untouched", d, 32'h0000_0001);
    rd(A_MASK, d);  chk("R9 mask untouched", d, 32'h0);
    rd(A_CTRL, d);  chk("R9 ctrl untouched", d, 32'h0000_0028);
    rd(8'h04, d);   chk("R9 unmapped read", d, 32'h0);
    rd(8'hFF, d);   chk("R9 unmapped read high", d, 32'h0);

    // R3 masking the pending line drops irq_out, raw cause unchanged
    wr(A_MASK, 32'h0000_0001);
    chk("R3 masked irq_out", {31'd0, irq_out}, 32'd0);
    rd(A_CAUSE, d); chk("R3 raw cause", d, 32'h0000_0001);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule